// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This block keeps a live count of packets that a DMA engine has finished but that software has not yet handled. Every completion pulse from the engine adds one to the count. Software subtracts one per handled packet by writing the value 1 to the count register. The interrupt request rises when the count reaches a programmable threshold. Software can therefore service a batch of packets per interrupt rather than take one interrupt per packet.

A batch may never reach the threshold, for example when traffic slows down. For that case a wait-bound timer, counted in millisecond ticks, raises the interrupt after a programmable time. The timer runs only while the count is nonzero and no interrupt is pending. Writes that adjust the threshold, the wait bound and the count share one small select-addressed write port. The stored values are driven out continuously so that they can be read back.

Top module: `pkt_coalesce`

## Requirements
- R1: After a synchronous active-high reset, the count, the threshold, the wait bound and the interrupt request are all 0.
- R2: Each cycle with `pkt_done_i` high raises the count by one. At its maximum (255 with the default width) the count holds instead of wrapping.
- R3: A write with select 0 and a data word of exactly 1 lowers the count by one. A select-0 write with any other data is ignored. A decrement while the count is 0 is ignored, so the count never goes below zero.
- R4: A packet pulse and an accepted decrement in the same cycle leave a nonzero count unchanged. When the count is 0, the decrement is refused and the result is 1. When the count is at its maximum, it stays at the maximum.
- R5: A write with select 1 stores bits 7:0 of the data as the threshold. A write with select 2 stores bits 9:0 as the wait bound. A write with select 3 changes nothing.
- R6: With a nonzero threshold, the interrupt is high whenever count >= threshold. A threshold of 0 never asserts the interrupt, and a count of 0 never asserts it at all.
- R7: With a nonzero wait bound W, a nonzero count and no interrupt pending, the interrupt rises right after the clock edge that takes the W-th millisecond tick. A wait bound of 0 disables the timer, and ticks while the count is 0 have no effect.
- R8: The timer reloads W whenever it stops running: when the count is 0 or an interrupt is pending. An interrupt raised by the timer stays high until the count returns to 0.
- R9: The count stays live while the interrupt is high: packet pulses and decrements keep changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 threshold, 2 wait bound, 3 reserved |
| wr_data_i | input | DATA_W (16) | Write data |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| count_o | output | CNT_W (8) | Live unserviced packet count |
| irq_o | output | 1 | Interrupt request |
| thresh_o | output | 8 | Stored threshold |
| wait_o | output | WAIT_W (10) | Stored wait bound |

## Verification
The engine's increment and software's decrement can land on the same clock edge. The bench provokes this by driving `pkt_done_i` together with a select-0 write of 1. It does so at a mid-range count, at zero and at the saturation limit. It judges the result by the count read back after that edge: unchanged, 1 and 255 respectively. The timer's tick-to-interrupt latency is also checked one tick short of the bound and at the bound, both with the timer freshly reloaded and with it held off by a threshold interrupt.

// File: rtl/pkt_coalesce_pkg.sv
package pkt_coalesce_pkg;

    localparam int THR_W      = 8;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_WAIT_W = 10;
    localparam int DEF_DATA_W = 16;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_WAIT   = 2'd2,
        SEL_RSVD   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic             hit_thresh;
        logic             hit_timeout;
    } irq_src_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pkt_coal_regs.sv
module pkt_coal_regs
    import pkt_coalesce_pkg::*;
#(
    parameter int WAIT_W = DEF_WAIT_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [THR_W-1:0]  thresh_o,
    output logic [WAIT_W-1:0] wait_o,
    output logic              dec_req_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [THR_W-1:0]  thr_q;
    logic [WAIT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            wait_q <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i == SEL_THRESH) thr_q  <= wr_data_i[THR_W-1:0];
            if (wr_sel_i == SEL_WAIT)   wait_q <= wr_data_i[WAIT_W-1:0];
        end
    end

    assign dec_req_o = wr_en_i && (wr_sel_i == SEL_COUNT) && (wr_data_i == ONE);
    assign thresh_o  = thr_q;
    assign wait_o    = wait_q;

    // R5: reserved select leaves both stored values alone
    assert_rsvd_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == SEL_RSVD) |=> ($stable(thr_q) && $stable(wait_q)));

endmodule

// File: rtl/pkt_coal_counter.sv
module pkt_coal_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             dec_req_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             dec_ok;

    assign dec_ok = dec_req_i && (count_q != '0);

    always_comb begin
        count_d = count_q;
        unique case ({inc_i, dec_ok})
            2'b10:   if (count_q != CNT_MAX) count_d = count_q + 1'b1;
            2'b01:   count_d = count_q - 1'b1;
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count_o = count_q;

    // R3: without a packet pulse a zero count cannot move
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !inc_i) |=> (count_q == '0));

    // R2: saturation at the top of the range
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && inc_i) |=> (count_q == CNT_MAX));

    // R4: simultaneous increment and decrement cancel
    assert_both_cancel_R4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && dec_req_i && count_q != '0) |=> $stable(count_q));

endmodule

// File: rtl/pkt_coal_timer.sv
module pkt_coal_timer #(
    parameter int WAIT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [WAIT_W-1:0] bound_i,
    input  logic              count_nz_i,
    input  logic              irq_pend_i,
    output logic              timeout_o
);

    logic [WAIT_W-1:0] remain_q;
    logic              expired_q;
    logic              armed;

    assign armed = count_nz_i && !irq_pend_i && (bound_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q  <= '0;
            expired_q <= 1'b0;
        end else begin
            if (!armed) begin
                remain_q <= bound_i;
            end else if (tick_i) begin
                if (remain_q <= WAIT_W'(1)) expired_q <= 1'b1;
                else                        remain_q  <= remain_q - 1'b1;
            end
            if (!count_nz_i) expired_q <= 1'b0;
        end
    end

    assign timeout_o = expired_q;

    // R7: a zero bound never lets the timer fire
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (bound_i == '0 && !expired_q) |=> !expired_q);

    // R8: an empty count clears a pending timeout
    assert_zero_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!count_nz_i) |=> !expired_q);

    // R8: once fired, the timeout holds while packets remain
    assert_timeout_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (expired_q && count_nz_i) |=> expired_q);

endmodule

// File: rtl/pkt_coalesce.sv
module pkt_coalesce
    import pkt_coalesce_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int WAIT_W = DEF_WAIT_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_done_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ms_tick_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic [THR_W-1:0]  thresh_o,
    output logic [WAIT_W-1:0] wait_o
);

    localparam int CMP_W = max_int(CNT_W, THR_W);

    logic [THR_W-1:0]  thr;
    logic [WAIT_W-1:0] wbound;
    logic              dec_req;
    logic [CNT_W-1:0]  count;
    logic              timeout;
    logic [CMP_W-1:0]  cnt_ext;
    logic [CMP_W-1:0]  thr_ext;
    irq_src_t          src;

    pkt_coal_regs #(.WAIT_W(WAIT_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .thresh_o  (thr),
        .wait_o    (wbound),
        .dec_req_o (dec_req)
    );

    pkt_coal_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .inc_i     (pkt_done_i),
        .dec_req_i (dec_req),
        .count_o   (count)
    );

    pkt_coal_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (ms_tick_i),
        .bound_i    (wbound),
        .count_nz_i (count != '0),
        .irq_pend_i (irq_o),
        .timeout_o  (timeout)
    );

    assign cnt_ext = CMP_W'(count);
    assign thr_ext = CMP_W'(thr);

    always_comb begin
        src.hit_thresh  = (thr != '0) && (cnt_ext >= thr_ext);
        src.hit_timeout = timeout && (count != '0);
    end

    assign irq_o    = src.hit_thresh | src.hit_timeout;
    assign count_o  = count;
    assign thresh_o = thr;
    assign wait_o   = wbound;

    // R6: an empty count never requests service
    assert_zero_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0) |-> !irq_o);

    // R6: zero threshold with no timeout keeps the request low
    assert_thr_off_R6: assert property (@(posedge clk) disable iff (rst)
        (thresh_o == '0 && !timeout) |-> !irq_o);

endmodule

// File: tb/pkt_coalesce_bench.sv
module pkt_coalesce_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {pkt, we, sel[1:0], data[15:0], tick, exp_count[7:0], exp_irq}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'd1, 16'h0103, 1'b0, 8'd0, 1'b0},  // threshold 3 (R5)
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd1, 1'b0},  // R2
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd2, 1'b0},
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd3, 1'b1},  // R6 at threshold
        {1'b1, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd3, 1'b1},  // R4 cancel
        {1'b0, 1'b1, 2'd0, 16'h0002, 1'b0, 8'd3, 1'b1},  // R3 bad data ignored
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd2, 1'b0},  // R3
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd3, 1'b1},
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd4, 1'b1},  // R9 live while irq
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd3, 1'b1},
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd2, 1'b0},
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd1, 1'b0},
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd0, 1'b0},
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd0, 1'b0},  // R3 at zero
        {1'b1, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd1, 1'b0},  // R4 at zero
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd0, 1'b0},
        {1'b0, 1'b1, 2'd3, 16'h0001, 1'b0, 8'd0, 1'b0},  // R5 reserved
        {1'b0, 1'b1, 2'd1, 16'h0000, 1'b0, 8'd0, 1'b0},  // threshold 0
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd1, 1'b0},  // R6 disabled
        {1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 8'd2, 1'b0},
        {1'b0, 1'b1, 2'd1, 16'h0002, 1'b0, 8'd2, 1'b1},  // R6 threshold lowered
        {1'b0, 1'b1, 2'd0, 16'h0001, 1'b0, 8'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_done;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        ms_tick;
    logic [7:0]  count;
    logic        irq;
    logic [7:0]  thresh;
    logic [9:0]  waitb;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_coalesce u_pkt_coalesce (
        .clk        (clk),
        .rst        (rst),
        .pkt_done_i (pkt_done),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .ms_tick_i  (ms_tick),
        .count_o    (count),
        .irq_o      (irq),
        .thresh_o   (thresh),
        .wait_o     (waitb)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic step(input logic p, input logic we, input logic [1:0] s,
                        input logic [15:0] d, input logic t);
        @(negedge clk);
        pkt_done = p; wr_en = we; wr_sel = s; wr_data = d; ms_tick = t;
        @(posedge clk);
        #1;
        pkt_done = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; ms_tick = 1'b0;
    endtask

    task automatic pkt();          step(1'b1, 1'b0, 2'd0, 16'h0, 1'b0); endtask
    task automatic dec();          step(1'b0, 1'b1, 2'd0, 16'h1, 1'b0); endtask
    task automatic tick();         step(1'b0, 1'b0, 2'd0, 16'h0, 1'b1); endtask
    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        step(1'b0, 1'b1, s, d, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pkt_done = 1'b0; wr_en = 1'b0; wr_sel = 2'd0;
        wr_data = '0; ms_tick = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 count", int'(count), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 thresh", int'(thresh), 0);
        check("R1 wait", int'(waitb), 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][29], VEC[i][28], VEC[i][27:26], VEC[i][25:10], VEC[i][9]);
            check($sformatf("R2/R3/R4/R6/R9 vec %0d count", i), int'(count), int'(VEC[i][8:1]));
            check($sformatf("R6 vec %0d irq", i), int'(irq), int'(VEC[i][0]));
        end
        dec();
        check("R3 back to zero", int'(count), 0);

        // R5 field widths
        wr(2'd1, 16'hFF00);
        check("R5 thresh low bits", int'(thresh), 0);
        wr(2'd2, 16'hFC03);
        check("R5 wait low bits", int'(waitb), 3);
        wr(2'd2, 16'hFFFF);
        check("R5 wait max", int'(waitb), 1023);
        wr(2'd3, 16'h0005);
        check("R5 rsvd wait", int'(waitb), 1023);
        wr(2'd2, 16'h0003);

        // R2 / R4 saturation
        for (int i = 0; i < 256; i++) pkt();
        check("R2 saturate", int'(count), 255);
        step(1'b1, 1'b1, 2'd0, 16'h1, 1'b0);
        check("R4 at max", int'(count), 255);
        check("R6 thr0 at max", int'(irq), 0);
        for (int i = 0; i < 255; i++) dec();
        check("R3 drained", int'(count), 0);

        // R7 timer fires on third tick with bound 3
        pkt();
        tick(); tick();
        check("R7 before bound", int'(irq), 0);
        tick();
        check("R7 at bound", int'(irq), 1);
        tick();
        pkt();
        check("R9 live count", int'(count), 2);
        check("R8 timeout held", int'(irq), 1);
        dec();
        check("R8 held after dec", int'(irq), 1);
        dec();
        check("R8 cleared at zero", int'(irq), 0);

        // R8 reload after count returns to zero
        pkt(); tick(); tick(); dec();
        pkt(); tick(); tick();
        check("R8 reload short", int'(irq), 0);
        tick();
        check("R8 reload full", int'(irq), 1);
        dec();
        check("R8 clear", int'(irq), 0);

        // R8 timer held off by threshold interrupt
        wr(2'd1, 16'h0002);
        pkt(); pkt();
        check("R6 thr irq", int'(irq), 1);
        tick(); tick(); tick(); tick();
        dec();
        check("R8 thr released", int'(irq), 0);
        tick(); tick();
        check("R8 reloaded after pend", int'(irq), 0);
        tick();
        check("R8 fires after reload", int'(irq), 1);
        dec();
        check("R8 zero clears", int'(irq), 0);

        // R7 bound zero and ticks at zero count
        wr(2'd1, 16'h0000);
        tick(); tick(); tick(); tick();
        check("R7 idle ticks", int'(irq), 0);
        wr(2'd2, 16'h0000);
        pkt();
        for (int i = 0; i < 5; i++) tick();
        check("R7 bound zero", int'(irq), 0);
        check("R7 count kept", int'(count), 1);
        dec();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule